// File: doc/BRIEF.md
# Three-Octave Streaming Wavelet Filter Engine

This block computes a one-dimensional discrete wavelet transform over a stream of signed 16-bit samples. It runs up to three decomposition octaves on a single pair of six-tap filters, one low-pass and one high-pass. A fixed eight-slot schedule shares that filter pair between the octaves. Every accepted sample advances the schedule by one slot. The slot decides which register bank feeds the filter taps: the input bank, the bank of first-octave low-pass results, or the bank of second-octave low-pass results. Some slots feed nothing. Low-pass results are written back into the bank that feeds the next octave, so the block needs no intermediate memory. One result slot is produced per accepted sample.

Coefficients are signed Q1.15 values written one at a time through a small load port. Each filter sums six products at full width, rounds to nearest with ties upward, and saturates back to 16 bits. Each detail output (high-pass) carries its octave number. The approximation output (low-pass) is emitted only for the deepest octave selected.

Top module: `dwt_octave_engine`

## Requirements
- R1: While `rst` is high and on the first clock after it falls, `det_vld` and `app_vld` are 0. Reset clears the schedule position, all three banks and all coefficients to zero.
- R2: Accepted samples are numbered by a slot counter s = 0..7 that starts at 0 after reset and advances by one per accepted sample. On slots 0, 2, 4 and 6 the filters read the current sample and the five samples before it. The octave-1 result appears on the outputs on the next clock edge.
- R3: Each filter output is y = sum over i of c[i]*w[i], where w[0] is the newest window value. It is then computed as (y + 16384) >>> 15 and clamped to the range -32768..32767.
- R4: On slots 3 and 7 the filters read the six most recent octave-1 low-pass results, newest as w[0], and produce an octave-2 result.
- R5: On slot 5 the filters read the six most recent octave-2 low-pass results and produce an octave-3 result.
- R6: Slot 1 is idle: no output is flagged valid on the following clock.
- R7: A detail result is emitted for octave k only when k is at most the selected depth `levels`, with 0 treated as 1. The approximation is emitted, in the same cycle as its detail, only when k equals that depth.
- R8: A cycle with `in_vld` low accepts no sample, does not advance the slot counter, changes no bank and flags no output on the next clock.
- R9: A write with `coef_we` high stores `coef_data` into tap `coef_idx` (0..5, 0 weighting the newest value). The high-pass set is written when `coef_hp` is 1, the low-pass set otherwise. The new value is used from the next clock on; a result computed in the write cycle uses the old value.
- R10: `det_oct` and `app_oct` give the octave of the result as 1, 2 or 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Sample present this cycle |
| in_data | input | 16 | Signed input sample |
| levels | input | 2 | Decomposition depth 1..3 (0 acts as 1) |
| coef_we | input | 1 | Coefficient write strobe |
| coef_hp | input | 1 | 1 selects high-pass set, 0 low-pass |
| coef_idx | input | 3 | Tap index of the write |
| coef_data | input | 16 | Signed Q1.15 coefficient |
| det_vld | output | 1 | Detail result valid |
| det_oct | output | 2 | Octave of the detail result |
| det_data | output | 16 | High-pass (detail) result |
| app_vld | output | 1 | Approximation result valid |
| app_oct | output | 2 | Octave of the approximation result |
| app_data | output | 16 | Low-pass (approximation) result |

## Verification
Two pairs of events can land in the same cycle. First, a result of the deepest selected octave raises both the detail and the approximation outputs together. This is provoked at each depth from 0 to 3, and the bench expects both flags and both values in that cycle and in no other. Second, a coefficient write can coincide with a computation that reads the same tap. The bench issues writes in the middle of a stream with valid samples and expects the old value to apply in the write cycle and the new one from the next slot on. A behavioural model built from queues predicts every output on every clock, including the saturating case and streams with gaps in the valid signal.

// File: rtl/dwt_pkg.sv
`timescale 1ns/1ps
package dwt_pkg;
  localparam int SCHED_LEN = 8;
  localparam int PH_W      = $clog2(SCHED_LEN);

  typedef enum logic [1:0] {
    FEED_IDLE  = 2'd0,
    FEED_INPUT = 2'd1,
    FEED_OCT2  = 2'd2,
    FEED_OCT3  = 2'd3
  } feed_sel_e;
endpackage

// File: rtl/dwt_bank.sv
`timescale 1ns/1ps
module dwt_bank #(
  parameter int DEPTH = 6,
  parameter int DW    = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        en,
  input  logic [DW-1:0]               din,
  output logic [DEPTH-1:0][DW-1:0]    taps
);
  always_ff @(posedge clk) begin
    if (rst) begin
      taps <= '0;
    end else if (en) begin
      taps[0] <= din;
      for (int i = 1; i < DEPTH; i++) taps[i] <= taps[i-1];
    end
  end
endmodule

// File: rtl/dwt_ctrl_switch.sv
`timescale 1ns/1ps
module dwt_ctrl_switch
  import dwt_pkg::*;
#(
  parameter int TAPS = 6,
  parameter int DW   = 16
) (
  input  logic [PH_W-1:0]          phase,
  input  logic [1:0]               lvl_eff,
  input  logic                     in_vld,
  input  logic [TAPS-1:0][DW-1:0]  win_in,
  input  logic [TAPS-1:0][DW-1:0]  win_l1,
  input  logic [TAPS-1:0][DW-1:0]  win_l2,
  output feed_sel_e                sel,
  output logic [1:0]               oct,
  output logic                     go,
  output logic [TAPS-1:0][DW-1:0]  win_out
);
  feed_sel_e sched;

  always_comb begin
    unique case (phase)
      3'd0, 3'd2, 3'd4, 3'd6: begin sched = FEED_INPUT; oct = 2'd1; end
      3'd3, 3'd7:             begin sched = FEED_OCT2;  oct = 2'd2; end
      3'd5:                   begin sched = FEED_OCT3;  oct = 2'd3; end
      default:                begin sched = FEED_IDLE;  oct = 2'd0; end
    endcase
    go  = in_vld && (oct != 2'd0) && (oct <= lvl_eff);
    sel = go ? sched : FEED_IDLE;
  end

  for (genvar t = 0; t < TAPS; t++) begin : g_tap_mux
    always_comb begin
      unique case (sel)
        FEED_INPUT: win_out[t] = win_in[t];
        FEED_OCT2:  win_out[t] = win_l1[t];
        FEED_OCT3:  win_out[t] = win_l2[t];
        default:    win_out[t] = '0;
      endcase
    end
  end
endmodule

// File: rtl/dwt_cell.sv
`timescale 1ns/1ps
module dwt_cell #(
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int AW = 36
) (
  input  logic signed [DW-1:0] x,
  input  logic signed [CW-1:0] c,
  input  logic signed [AW-1:0] psum_i,
  output logic signed [AW-1:0] psum_o
);
  logic signed [DW+CW-1:0] prod;
  assign prod   = x * c;
  assign psum_o = psum_i + AW'(prod);
endmodule

// File: rtl/dwt_octave_engine.sv
`timescale 1ns/1ps
module dwt_octave_engine
  import dwt_pkg::*;
#(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int TAPS = 6
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          in_vld,
  input  logic [DW-1:0]                 in_data,
  input  logic [1:0]                    levels,
  input  logic                          coef_we,
  input  logic                          coef_hp,
  input  logic [$clog2(TAPS)-1:0]       coef_idx,
  input  logic [CW-1:0]                 coef_data,
  output logic                          det_vld,
  output logic [1:0]                    det_oct,
  output logic [DW-1:0]                 det_data,
  output logic                          app_vld,
  output logic [1:0]                    app_oct,
  output logic [DW-1:0]                 app_data
);
  localparam int IW = $clog2(TAPS);
  localparam int AW = DW + CW + $clog2(TAPS) + 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(TAPS - 1);
  localparam logic signed [AW-1:0] MAXV = (AW'(1) <<< (DW - 1)) - AW'(1);
  localparam logic signed [AW-1:0] MINV = -(AW'(1) <<< (DW - 1));
  localparam logic signed [AW-1:0] HALF = AW'(1) <<< (CW - 2);

  logic [PH_W-1:0]          phase_q;
  logic [1:0]               lvl_eff;
  logic [TAPS-1:0][DW-1:0]  ib_taps, l1_taps, l2_taps, win_in, win_sel;
  logic [TAPS-1:0][CW-1:0]  h_q, g_q;
  feed_sel_e                sel;
  logic [1:0]               oct;
  logic                     go;
  logic signed [AW-1:0]     lp_ps [TAPS+1];
  logic signed [AW-1:0]     hp_ps [TAPS+1];
  logic [DW-1:0]            lp_res, hp_res;

  assign lvl_eff = (levels == 2'd0) ? 2'd1 : levels;

  always_ff @(posedge clk) begin
    if (rst)         phase_q <= '0;
    else if (in_vld) phase_q <= phase_q + 1'b1;
  end

  // Octave-1 window: the arriving sample plus the newest stored ones.
  always_comb begin
    win_in[0] = in_data;
    for (int i = 1; i < TAPS; i++) win_in[i] = ib_taps[i-1];
  end

  dwt_bank #(.DEPTH(TAPS), .DW(DW)) ib_i (
    .clk(clk), .rst(rst), .en(in_vld), .din(in_data), .taps(ib_taps));
  dwt_bank #(.DEPTH(TAPS), .DW(DW)) l1_i (
    .clk(clk), .rst(rst), .en(go && oct == 2'd1), .din(lp_res), .taps(l1_taps));
  dwt_bank #(.DEPTH(TAPS), .DW(DW)) l2_i (
    .clk(clk), .rst(rst), .en(go && oct == 2'd2), .din(lp_res), .taps(l2_taps));

  dwt_ctrl_switch #(.TAPS(TAPS), .DW(DW)) sw_i (
    .phase(phase_q), .lvl_eff(lvl_eff), .in_vld(in_vld),
    .win_in(win_in), .win_l1(l1_taps), .win_l2(l2_taps),
    .sel(sel), .oct(oct), .go(go), .win_out(win_sel));

  always_ff @(posedge clk) begin
    if (rst) begin
      h_q <= '0;
      g_q <= '0;
    end else if (coef_we && coef_idx <= LAST_IDX) begin
      if (coef_hp) g_q[coef_idx] <= coef_data;
      else         h_q[coef_idx] <= coef_data;
    end
  end

  assign lp_ps[0] = '0;
  assign hp_ps[0] = '0;
  for (genvar t = 0; t < TAPS; t++) begin : g_cells
    dwt_cell #(.DW(DW), .CW(CW), .AW(AW)) lp_cell_i (
      .x($signed(win_sel[t])), .c($signed(h_q[t])),
      .psum_i(lp_ps[t]), .psum_o(lp_ps[t+1]));
    dwt_cell #(.DW(DW), .CW(CW), .AW(AW)) hp_cell_i (
      .x($signed(win_sel[t])), .c($signed(g_q[t])),
      .psum_i(hp_ps[t]), .psum_o(hp_ps[t+1]));
  end

  function automatic logic [DW-1:0] rnd_sat(input logic signed [AW-1:0] a);
    logic signed [AW-1:0] r;
    r = (a + HALF) >>> (CW - 1);
    if (r > MAXV)      r = MAXV;
    else if (r < MINV) r = MINV;
    return r[DW-1:0];
  endfunction

  assign lp_res = rnd_sat(lp_ps[TAPS]);
  assign hp_res = rnd_sat(hp_ps[TAPS]);

  always_ff @(posedge clk) begin
    if (rst) begin
      det_vld  <= 1'b0;
      det_oct  <= '0;
      det_data <= '0;
      app_vld  <= 1'b0;
      app_oct  <= '0;
      app_data <= '0;
    end else begin
      det_vld <= go;
      app_vld <= go && (oct == lvl_eff);
      if (go) begin
        det_oct  <= oct;
        det_data <= hp_res;
        app_oct  <= oct;
        app_data <= lp_res;
      end
    end
  end
endmodule

// File: rtl/dwt_octave_engine_chk.sv
`timescale 1ns/1ps
module dwt_octave_engine_chk #(
  parameter int PW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          in_vld,
  input logic          det_vld,
  input logic [1:0]    det_oct,
  input logic          app_vld,
  input logic [1:0]    app_oct,
  input logic [PW-1:0] phase_q
);
  assert_no_idle_output_R8: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> (!det_vld && !app_vld));

  assert_pair_with_detail_R7: assert property (@(posedge clk) disable iff (rst)
    app_vld |-> (det_vld && det_oct == app_oct));

  assert_tag_nonzero_R10: assert property (@(posedge clk) disable iff (rst)
    det_vld |-> (det_oct != 2'd0));

  assert_oct1_even_slot_R2: assert property (@(posedge clk) disable iff (rst)
    (in_vld && phase_q[0] == 1'b0) |=> (det_vld && det_oct == 2'd1));

  assert_oct3_slot_R5: assert property (@(posedge clk) disable iff (rst)
    (in_vld && phase_q != 3'd5) |=> !(det_vld && det_oct == 2'd3));

  assert_slot1_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (in_vld && phase_q == 3'd1) |=> !det_vld);
endmodule

bind dwt_octave_engine dwt_octave_engine_chk #(.PW(dwt_pkg::PH_W)) chk_i (
  .clk(clk), .rst(rst), .in_vld(in_vld), .det_vld(det_vld), .det_oct(det_oct),
  .app_vld(app_vld), .app_oct(app_oct), .phase_q(phase_q));

// File: tb/dwt_octave_engine_tb_top.sv
`timescale 1ns/1ps
module dwt_octave_engine_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1, in_vld = 1'b0, coef_we = 1'b0, coef_hp = 1'b0;
  logic [15:0] in_data = '0, coef_data = '0;
  logic [1:0] levels = 2'd3;
  logic [2:0] coef_idx = '0;
  logic det_vld, app_vld;
  logic [1:0] det_oct, app_oct;
  logic [15:0] det_data, app_data;

  dwt_octave_engine dut_i (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_data(in_data), .levels(levels),
    .coef_we(coef_we), .coef_hp(coef_hp), .coef_idx(coef_idx), .coef_data(coef_data),
    .det_vld(det_vld), .det_oct(det_oct), .det_data(det_data),
    .app_vld(app_vld), .app_oct(app_oct), .app_data(app_data));

  int n_chk = 0, n_fail = 0;
  string tag = "";

  // Behavioural reference: queues of history, newest at the front.
  int hq[6], gq[6];
  int xq[$], l1q[$], l2q[$];
  int slot;
  bit e_dv, e_av;
  int e_dd, e_do, e_ad, e_ao;

  function automatic int rsat(longint a);
    longint r = (a + 16384) >>> 15;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  function automatic int fir(int q[$], int c[6]);
    longint acc = 0;
    for (int i = 0; i < 6; i++) acc += longint'(q[i]) * longint'(c[i]);
    return rsat(acc);
  endfunction

  task automatic model_clear();
    xq.delete(); l1q.delete(); l2q.delete();
    for (int i = 0; i < 6; i++) begin
      xq.push_back(0); l1q.push_back(0); l2q.push_back(0);
      hq[i] = 0; gq[i] = 0;
    end
    slot = 0; e_dv = 0; e_av = 0;
  endtask

  task automatic model_step(bit r, bit v, int x, int lv, bit we, bit hp, int idx, int d);
    int oc, le, lp, hpv;
    e_dv = 0; e_av = 0;
    if (r) begin model_clear(); return; end
    if (v) begin
      xq.push_front(x); void'(xq.pop_back());
      oc = (slot % 2 == 0) ? 1 : (slot == 3 || slot == 7) ? 2 : (slot == 5) ? 3 : 0;
      le = (lv == 0) ? 1 : lv;
      if (oc != 0 && oc <= le) begin
        if (oc == 1)      begin lp = fir(xq, hq);  hpv = fir(xq, gq);  end
        else if (oc == 2) begin lp = fir(l1q, hq); hpv = fir(l1q, gq); end
        else              begin lp = fir(l2q, hq); hpv = fir(l2q, gq); end
        e_dv = 1; e_dd = hpv; e_do = oc;
        if (oc == le) begin e_av = 1; e_ad = lp; e_ao = oc; end
        if (oc == 1) begin l1q.push_front(lp); void'(l1q.pop_back()); end
        if (oc == 2) begin l2q.push_front(lp); void'(l2q.pop_back()); end
      end
      slot = (slot + 1) % 8;
    end
    if (we && idx < 6) begin
      if (hp) gq[idx] = d; else hq[idx] = d;
    end
  endtask

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One clock: compare what the last edge produced, then drive the next inputs.
  task automatic cycle(bit r, bit v, int x, int lv, bit we = 0, bit hp = 0, int idx = 0, int d = 0);
    string rq;
    @(negedge clk);
    if (tag != "") rq = tag;
    else rq = (e_do == 1) ? "R2" : (e_do == 2) ? "R4" : (e_do == 3) ? "R5" : "R6";
    if (!e_dv && tag == "") rq = "R6";
    check(rq, "det_vld", int'(det_vld), int'(e_dv));
    check(rq, "app_vld", int'(app_vld), int'(e_av));
    if (e_dv) begin
      check(rq, "det_data", int'($signed(det_data)), e_dd);
      check("R10", "det_oct", int'(det_oct), e_do);
    end
    if (e_av) begin
      check(rq, "app_data", int'($signed(app_data)), e_ad);
      check("R10", "app_oct", int'(app_oct), e_ao);
    end
    model_step(r, v, x, lv, we, hp, idx, d);
    rst = r; in_vld = v; in_data = 16'(x); levels = 2'(lv);
    coef_we = we; coef_hp = hp; coef_idx = 3'(idx); coef_data = 16'(d);
  endtask

  task automatic load(int h[6], int g[6], int lv);
    for (int i = 0; i < 6; i++) cycle(0, 0, 0, lv, 1, 0, i, h[i]);
    for (int i = 0; i < 6; i++) cycle(0, 0, 0, lv, 1, 1, i, g[i]);
  endtask

  task automatic do_reset(int lv);
    for (int i = 0; i < 3; i++) cycle(1, 0, 0, lv);
    cycle(0, 0, 0, lv);
  endtask

  function automatic int rnd_s16();
    return int'($urandom_range(65535)) - 32768;
  endfunction

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int h[6] = '{10903, 26441, 15071, -4424, -2799, 1154};
    int g[6] = '{1154, 2799, -4424, -15071, 26441, -10903};
    int hs[6] = '{32767, 32767, 32767, 32767, 32767, 32767};
    int gs[6] = '{-32768, -32768, -32768, -32768, -32768, -32768};
    model_clear();
    tag = "R1";
    do_reset(3);
    cycle(0, 0, 0, 3);
    tag = "R9";
    load(h, g, 3);
    tag = "";
    for (int i = 0; i < 400; i++) cycle(0, 1, rnd_s16(), 3);
    tag = "R8";
    for (int i = 0; i < 400; i++) cycle(0, $urandom_range(1), rnd_s16(), 3);
    tag = "R9";
    for (int i = 0; i < 160; i++)
      cycle(0, 1, rnd_s16(), 3, (i % 5 == 0), i[0], (i / 5) % 6, rnd_s16() / 2);
    tag = "R7";
    for (int lv = 0; lv < 3; lv++) begin
      do_reset(lv);
      load(h, g, lv);
      for (int i = 0; i < 120; i++) cycle(0, 1, rnd_s16(), lv);
    end
    tag = "R3";
    do_reset(3);
    load(hs, gs, 3);
    for (int i = 0; i < 120; i++) cycle(0, 1, ($urandom_range(1) != 0) ? 32767 : -32768, 3);
    for (int i = 0; i < 40; i++) cycle(0, 1, 32767, 3);
    tag = "";
    cycle(0, 0, 0, 3);
    cycle(0, 0, 0, 3);
    finish_run();
  end
endmodule